// File: doc/BRIEF.md
# Byte-Strobed Memory Port Responder

This block stands in for the host-memory side of a simplified memory port running on one clock. A requester issues word writes with per-byte strobes and word reads, each tagged with a 6-bit transaction ID. Writes land in an internal RAM and their completions come back on a separate response handshake. The delay of that response is set at run time from a 4-bit latency input, sampled with each write. Reads return the stored word, or an error code when the word lies outside the RAM.

The data word width is a parameter of 2, 4 or 8 bytes. The low address bits that select a byte inside a word are ignored. Completions are handed back strictly in the order the writes were accepted. A write whose delay expires early waits behind any older write that has not yet been acknowledged. The RAM clears to zero on reset.

Top module: `memport_responder`

## Requirements
- R1: `wr_ready` is high whenever fewer than QDEPTH write completions are pending. A write is accepted on every rising edge where `wr_valid` and `wr_ready` are both high. With QDEPTH completions pending, `wr_ready` is low and a presented write is not accepted.
- R2: The word index is the byte address shifted right by log2(DATA_BYTES). With the default 8 bytes, address bits [2:0] are ignored.
- R3: On an accepted in-range write, byte lane i (bits 8i+7..8i) is updated only when `wr_strb[i]` is 1. All other lanes keep their old contents, and a strobe of all zeros changes nothing.
- R4: Suppose a write with ID n is accepted at edge k with `wr_lat` = L, and no older completion is pending. Then `b_valid` is high with `b_id` = n from edge k+L onward, and holds until an edge where `b_ready` is high.
- R5: Completions leave in acceptance order. While `b_valid` is high and `b_ready` is low, `b_valid` and `b_id` stay unchanged. A younger completion whose delay has expired waits until every older one has been taken.
- R6: `rd_req_ready` is always high. A read request accepted at edge k produces `rd_valid` high for exactly the cycle after edge k. In that cycle, `rd_rid` equals the request's ID, `rd_resp` = 0 and `rd_data` is the stored word.
- R7: A read whose word index is DEPTH or above returns `rd_resp` = 2 with `rd_data` zero. A write to such an index changes no stored word, yet still receives its completion.
- R8: After reset, `b_valid` and `rd_valid` are low and every stored word reads as zero.
- R9: When a read and a write of the same word are accepted at the same edge, the read returns the contents from before that write. The next read of that word returns the new contents.
- R10: `rd_data` is zero in every cycle where `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_addr | input | ADDR_W | Write byte address |
| wr_id | input | ID_W | Write transaction ID |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write can be accepted |
| wr_data | input | 8*DATA_BYTES | Write data word |
| wr_strb | input | DATA_BYTES | Per-byte write enables |
| wr_lat | input | LAT_W | Completion delay in cycles for this write |
| b_valid | output | 1 | Write completion present |
| b_id | output | ID_W | ID of the completed write |
| b_ready | input | 1 | Requester takes the completion |
| rd_addr | input | ADDR_W | Read byte address |
| rd_id | input | ID_W | Read transaction ID |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Read can be accepted (always high) |
| rd_valid | output | 1 | Read result present, one cycle |
| rd_data | output | 8*DATA_BYTES | Read data word |
| rd_resp | output | 2 | 0 success, 2 error |
| rd_rid | output | ID_W | ID of the answered read |

## Verification
A read and a write of the same word can be accepted on one edge. The bench provokes this by presenting both requests in the same cycle, after first storing a known value. It then judges that the read returns the old value and that a following read returns the new one.

A completion falling due can also coincide with a younger write whose delay is zero. This is provoked by a long-delay write followed at once by a zero-delay one. The bench judges that `b_valid` stays low until the older delay ends, and that the two IDs emerge in acceptance order.

// File: rtl/memport_pkg.sv
package memport_pkg;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'd0,
        RESP_SLVERR = 2'd2
    } resp_e;

    function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
        return (p == depth - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/memport_store.sv
module memport_store #(
    parameter int DATA_BYTES = 8,
    parameter int DEPTH      = 16,
    localparam int DATA_W    = 8 * DATA_BYTES,
    localparam int IDX_W     = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDX_W-1:0]      w_idx,
    input  logic [DATA_W-1:0]     w_data,
    input  logic [DATA_BYTES-1:0] w_strb,
    input  logic                  re,
    input  logic [IDX_W-1:0]      r_idx,
    output logic [DATA_W-1:0]     r_word
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            rword;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // read sees contents from before any write at the same edge
        st_d.rword = re ? st_q.mem[r_idx] : '0;
        if (we) begin
            for (int b = 0; b < DATA_BYTES; b++) begin
                if (w_strb[b]) begin
                    st_d.mem[w_idx][b*8 +: 8] = w_data[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign r_word = st_q.rword;

    // R10
    idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> (r_word == '0));

endmodule

// File: rtl/memport_resp_queue.sv
module memport_resp_queue
    import memport_pkg::*;
#(
    parameter int ID_W   = 6,
    parameter int LAT_W  = 4,
    parameter int QDEPTH = 8,
    localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ID_W-1:0]  push_id,
    input  logic [LAT_W-1:0] push_lat,
    input  logic             pop_ready,
    output logic             full,
    output logic             due,
    output logic [ID_W-1:0]  head_id
);

    typedef struct packed {
        logic [QDEPTH-1:0][ID_W-1:0]  ids;
        logic [QDEPTH-1:0][LAT_W-1:0] wait_cnt;
        logic [PTR_W-1:0]             rptr;
        logic [PTR_W-1:0]             wptr;
        logic [CNT_W-1:0]             fill;
    } queue_t;

    queue_t qs_d, qs_q;
    logic   pop;

    assign full    = (qs_q.fill == CNT_W'(QDEPTH));
    assign due     = (qs_q.fill != '0) && (qs_q.wait_cnt[qs_q.rptr] == '0);
    assign head_id = qs_q.ids[qs_q.rptr];
    assign pop     = due && pop_ready;

    always_comb begin
        qs_d = qs_q;
        for (int i = 0; i < QDEPTH; i++) begin
            if (qs_q.wait_cnt[i] != '0) begin
                qs_d.wait_cnt[i] = qs_q.wait_cnt[i] - 1'b1;
            end
        end
        if (pop) begin
            qs_d.rptr = PTR_W'(ring_next(int'(qs_q.rptr), QDEPTH));
        end
        if (push) begin
            qs_d.ids[qs_q.wptr]      = push_id;
            qs_d.wait_cnt[qs_q.wptr] = push_lat;
            qs_d.wptr = PTR_W'(ring_next(int'(qs_q.wptr), QDEPTH));
        end
        case ({push, pop})
            2'b10:   qs_d.fill = qs_q.fill + 1'b1;
            2'b01:   qs_d.fill = qs_q.fill - 1'b1;
            default: qs_d.fill = qs_q.fill;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qs_q <= '0;
        else        qs_q <= qs_d;
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R1
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qs_q.fill <= CNT_W'(QDEPTH));

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !pop_ready) |=> (due && $stable(head_id)));

    // R4
    zero_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && qs_q.fill == '0 && push_lat == '0) |=> (due && head_id == $past(push_id)));

endmodule

// File: rtl/memport_responder.sv
module memport_responder
    import memport_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ID_W       = 6,
    parameter int DATA_BYTES = 8,
    parameter int DEPTH      = 16,
    parameter int LAT_W      = 4,
    parameter int QDEPTH     = 8,
    localparam int DATA_W    = 8 * DATA_BYTES,
    localparam int LSB       = $clog2(DATA_BYTES),
    localparam int FIDX_W    = ADDR_W - LSB,
    localparam int IDX_W     = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [ID_W-1:0]       wr_id,
    input  logic                  wr_valid,
    output logic                  wr_ready,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DATA_BYTES-1:0] wr_strb,
    input  logic [LAT_W-1:0]      wr_lat,
    output logic                  b_valid,
    output logic [ID_W-1:0]       b_id,
    input  logic                  b_ready,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [ID_W-1:0]       rd_id,
    input  logic                  rd_req_valid,
    output logic                  rd_req_ready,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic [1:0]            rd_resp,
    output logic [ID_W-1:0]       rd_rid
);

    typedef struct packed {
        logic            rvalid;
        resp_e           rresp;
        logic [ID_W-1:0] rid;
    } rsp_t;

    rsp_t rs_d, rs_q;

    logic              q_full;
    logic              wr_fire, rd_fire;
    logic [FIDX_W-1:0] w_full_idx, r_full_idx;
    logic              w_ok, r_ok;

    assign w_full_idx   = wr_addr[ADDR_W-1:LSB];
    assign r_full_idx   = rd_addr[ADDR_W-1:LSB];
    assign w_ok         = (w_full_idx < FIDX_W'(DEPTH));
    assign r_ok         = (r_full_idx < FIDX_W'(DEPTH));
    assign wr_ready     = !q_full;
    assign rd_req_ready = 1'b1;
    assign wr_fire      = wr_valid && wr_ready;
    assign rd_fire      = rd_req_valid && rd_req_ready;

    memport_store #(
        .DATA_BYTES(DATA_BYTES),
        .DEPTH     (DEPTH)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_fire && w_ok),
        .w_idx (w_full_idx[IDX_W-1:0]),
        .w_data(wr_data),
        .w_strb(wr_strb),
        .re    (rd_fire && r_ok),
        .r_idx (r_full_idx[IDX_W-1:0]),
        .r_word(rd_data)
    );

    memport_resp_queue #(
        .ID_W  (ID_W),
        .LAT_W (LAT_W),
        .QDEPTH(QDEPTH)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wr_fire),
        .push_id  (wr_id),
        .push_lat (wr_lat),
        .pop_ready(b_ready),
        .full     (q_full),
        .due      (b_valid),
        .head_id  (b_id)
    );

    always_comb begin
        rs_d        = rs_q;
        rs_d.rvalid = rd_fire;
        rs_d.rresp  = (rd_fire && !r_ok) ? RESP_SLVERR : RESP_OKAY;
        rs_d.rid    = rd_fire ? rd_id : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '{rvalid: 1'b0, rresp: RESP_OKAY, rid: '0};
        else        rs_q <= rs_d;
    end

    assign rd_valid = rs_q.rvalid;
    assign rd_resp  = rs_q.rresp;
    assign rd_rid   = rs_q.rid;

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |=> rd_valid);

    // R6
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_valid |=> !rd_valid);

    // R6
    rid_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |=> (rd_rid == $past(rd_id)));

    // R7
    err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_resp == 2'd2) |-> (rd_data == '0));

    // R10
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

endmodule

// File: tb/memport_responder_test.sv
module memport_responder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [5:0]  wr_id = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_strb = '0;
    logic [3:0]  wr_lat = '0;
    logic        b_valid;
    logic [5:0]  b_id;
    logic        b_ready = 1'b0;
    logic [31:0] rd_addr = '0;
    logic [5:0]  rd_id = '0;
    logic        rd_req_valid = 1'b0;
    logic        rd_req_ready;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [1:0]  rd_resp;
    logic [5:0]  rd_rid;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    memport_responder uut (
        .clk(clk), .rst_n(rst_n),
        .wr_addr(wr_addr), .wr_id(wr_id), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .wr_strb(wr_strb), .wr_lat(wr_lat),
        .b_valid(b_valid), .b_id(b_id), .b_ready(b_ready),
        .rd_addr(rd_addr), .rd_id(rd_id), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_resp(rd_resp), .rd_rid(rd_rid)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one read issued at a negedge; result checked after the next edge
    task automatic do_read(input logic [31:0] a, input logic [5:0] id,
                           input logic [1:0] exp_resp, input logic [63:0] exp_data, input string tag);
        rd_addr = a; rd_id = id; rd_req_valid = 1'b1;
        @(negedge clk);
        rd_req_valid = 1'b0;
        chk(rd_valid == 1'b1, {tag, " R6 valid"}, 64'(rd_valid), 64'd1);
        chk(rd_resp == exp_resp, {tag, " resp"}, 64'(rd_resp), 64'(exp_resp));
        chk(rd_data == exp_data, {tag, " data"}, rd_data, exp_data);
        chk(rd_rid == id, {tag, " R6 rid"}, 64'(rd_rid), 64'(id));
        @(negedge clk);
        chk(rd_valid == 1'b0, "R6 single pulse", 64'(rd_valid), 64'd0);
        chk(rd_data == '0, "R10 idle data", rd_data, 64'd0);
    endtask

    localparam int NROW = 6;
    localparam logic [31:0] T_WADDR [NROW] = '{32'h08, 32'h0D, 32'h10, 32'h78, 32'h17, 32'h80};
    localparam logic [63:0] T_WDATA [NROW] = '{64'h1122334455667788, 64'hAAAAAAAAAAAAAAAA,
        64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF, 64'h0, 64'hFFFFFFFFFFFFFFFF};
    localparam logic [7:0]  T_STRB  [NROW] = '{8'hFF, 8'h0F, 8'h81, 8'hFF, 8'h00, 8'hFF};
    localparam logic [31:0] T_RADDR [NROW] = '{32'h08, 32'h0F, 32'h10, 32'h7C, 32'h10, 32'h00};
    localparam logic [63:0] T_REXP  [NROW] = '{64'h1122334455667788, 64'h11223344AAAAAAAA,
        64'hFF000000000000FF, 64'h0123456789ABCDEF, 64'hFF000000000000FF, 64'h0};

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        chk(b_valid == 1'b0, "R8 b_valid after reset", 64'(b_valid), 64'd0);
        chk(rd_valid == 1'b0, "R8 rd_valid after reset", 64'(rd_valid), 64'd0);
        chk(wr_ready == 1'b1, "R1 wr_ready after reset", 64'(wr_ready), 64'd1);
        chk(rd_req_ready == 1'b1, "R6 rd_req_ready", 64'(rd_req_ready), 64'd1);
        do_read(32'h28, 6'd50, 2'd0, 64'd0, "R8 cleared word");

        // table: write (R2, R3, R7 dropped write), zero-latency completion (R4), read back
        for (int i = 0; i < NROW; i++) begin
            wr_addr = T_WADDR[i]; wr_data = T_WDATA[i]; wr_strb = T_STRB[i];
            wr_id = 6'(i); wr_lat = 4'd0; wr_valid = 1'b1;
            @(negedge clk);
            wr_valid = 1'b0;
            chk(b_valid == 1'b1 && b_id == 6'(i), "R4 zero-latency completion", 64'(b_id), 64'(i));
            b_ready = 1'b1;
            @(negedge clk);
            b_ready = 1'b0;
            chk(b_valid == 1'b0, "R5 completion taken", 64'(b_valid), 64'd0);
            do_read(T_RADDR[i], 6'(i + 32), 2'd0, T_REXP[i], "R2/R3/R7 table row");
        end

        // R7 out-of-range reads
        do_read(32'h80, 6'd17, 2'd2, 64'd0, "R7 index DEPTH");
        do_read(32'hFFFF_FFF8, 6'd18, 2'd2, 64'd0, "R7 top address");

        // R4 latency 3, then R5 hold while b_ready low
        wr_addr = 32'h30; wr_data = 64'h5; wr_strb = 8'hFF; wr_id = 6'd12; wr_lat = 4'd3;
        wr_valid = 1'b1;
        for (int j = 0; j <= 3; j++) begin
            @(negedge clk);
            wr_valid = 1'b0;
            chk(b_valid == (j == 3), "R4 latency 3 timing", 64'(b_valid), 64'(j == 3));
        end
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(b_valid == 1'b1 && b_id == 6'd12, "R5 hold without b_ready", 64'(b_id), 64'd12);
        end
        b_ready = 1'b1;
        @(negedge clk);
        b_ready = 1'b0;
        chk(b_valid == 1'b0, "R5 taken after hold", 64'(b_valid), 64'd0);

        // R5 ordering: older long delay, younger zero delay
        wr_id = 6'd5; wr_lat = 4'd6; wr_valid = 1'b1;
        @(negedge clk);
        wr_id = 6'd9; wr_lat = 4'd0;
        for (int j = 1; j <= 6; j++) begin
            @(negedge clk);
            wr_valid = 1'b0;
            chk(b_valid == (j == 6), "R5 younger waits for older", 64'(b_valid), 64'(j == 6));
        end
        chk(b_id == 6'd5, "R5 older first", 64'(b_id), 64'd5);
        b_ready = 1'b1;
        @(negedge clk);
        chk(b_valid == 1'b1 && b_id == 6'd9, "R5 younger second", 64'(b_id), 64'd9);
        @(negedge clk);
        b_ready = 1'b0;
        chk(b_valid == 1'b0, "R5 queue drained", 64'(b_valid), 64'd0);

        // R9 read and write of the same word at one edge
        b_ready = 1'b1;
        wr_addr = 32'h18; wr_data = 64'hDEADBEEF00C0FFEE; wr_strb = 8'hFF; wr_lat = 4'd0;
        wr_id = 6'd20; wr_valid = 1'b1;
        @(negedge clk);
        wr_data = 64'h0F0F0F0F0F0F0F0F; wr_id = 6'd21;
        rd_addr = 32'h18; rd_id = 6'd22; rd_req_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; rd_req_valid = 1'b0;
        chk(rd_data == 64'hDEADBEEF00C0FFEE, "R9 same-edge read sees old", rd_data, 64'hDEADBEEF00C0FFEE);
        @(negedge clk);
        do_read(32'h18, 6'd23, 2'd0, 64'h0F0F0F0F0F0F0F0F, "R9 next read sees new");
        @(negedge clk);
        b_ready = 1'b0;
        chk(b_valid == 1'b0, "R5 drained after R9", 64'(b_valid), 64'd0);

        // R1 fill the completion queue
        wr_lat = 4'd0; wr_valid = 1'b1;
        for (int j = 0; j < 8; j++) begin
            wr_id = 6'(j);
            @(negedge clk);
        end
        chk(wr_ready == 1'b0, "R1 ready low when full", 64'(wr_ready), 64'd0);
        wr_id = 6'd40;
        @(negedge clk);
        wr_valid = 1'b0;
        b_ready = 1'b1;
        begin
            int seen = 0;
            bit stray = 1'b0;
            for (int j = 0; j < 10; j++) begin
                if (b_valid) begin
                    if (b_id != 6'(seen)) stray = 1'b1;
                    seen++;
                end
                @(negedge clk);
            end
            chk(seen == 8, "R1 completions after full", 64'(seen), 64'd8);
            chk(!stray, "R1 refused write not queued", 64'(stray), 64'd0);
        end
        b_ready = 1'b0;
        chk(wr_ready == 1'b1, "R1 ready restored", 64'(wr_ready), 64'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule